// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block produces the frame sync (VS), line sync (HS) and active-data (DE) strobes for a synthetic video stream at one pixel per clock. It also drives a pixel column and row index. Each strobe edge is placed by register values counted in pixel clocks.

A frame counter runs from zero up to the frame period, which is the VS high length plus the VS low length. VS rises after a programmed delay. The HS and DE trains each begin at their own absolute offset from frame start. Each train then emits a fixed number of pulses, each made of a high phase and a low phase, and stays low for the rest of the frame. For standard raster timing, software loads VS high as sync lines times line length and loads the DE offset as line length times (sync + back-porch lines) plus (sync + back-porch pixels).

All parameters are copied into shadow registers when a frame starts, so a new setting applied mid-frame takes effect cleanly at the next frame. An enable input gates the whole block.

Top module: `sync_timing_gen`

## Requirements
- R1: When enable is sampled low at a clock edge, from that edge on all strobes are low and both pixel indices are zero; the same holds after reset.
- R2: Let k be the frame position, 0 in the cycle after enable is first sampled high or after the last position of a frame. The frame period is VS high + VS low clocks, and VS is high exactly for VS delay <= k < VS delay + VS high.
- R3: HS is high when k >= HS offset, (k - HS offset) < HS count × (HS high + HS low) and (k - HS offset) mod (HS high + HS low) < HS high; otherwise low.
- R4: DE follows the rule of R3 using the DE offset, DE high, DE low and DE count.
- R5: pix_x_o equals (k - DE offset) mod (DE high + DE low) while DE is high, and is 0 while DE is low.
- R6: pix_y_o is 0 before the DE offset or when DE count is 0. Otherwise it is min((k - DE offset) / (DE high + DE low), DE count - 1), and this value holds until the frame ends.
- R7: Parameter inputs are captured only at frame start. A change during a frame does not affect that frame, and it applies from the next frame.
- R8: A train whose offset is at or beyond the frame period, or whose count is 0, stays low for the whole frame.
- R9: Dropping enable mid-frame clears the strobes at the next edge, and raising it again starts a fresh frame at k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| vs_dly_i | input | 24 | Clocks from frame start to VS rise |
| vs_high_i | input | 24 | VS high length |
| vs_low_i | input | 24 | VS low length |
| hs_off_i | input | 24 | Frame position of the first HS pulse |
| hs_high_i | input | 16 | HS high width |
| hs_low_i | input | 16 | HS low width |
| hs_cnt_i | input | 16 | HS pulses per frame |
| de_off_i | input | 24 | Frame position of the first DE pulse |
| de_high_i | input | 16 | DE high width (active pixels) |
| de_low_i | input | 16 | DE low width (blanking) |
| de_cnt_i | input | 16 | DE pulses per frame (active lines) |
| vs_o | output | 1 | Frame sync |
| hs_o | output | 1 | Line sync |
| de_o | output | 1 | Data enable |
| pix_x_o | output | 16 | Pixel index within the current DE pulse |
| pix_y_o | output | 16 | Index of the current or last DE line |

## Verification
The bench sweeps the HS high width, low width, count and offset over a small grid. It targets a zero low width, where pulses merge and a design that keys on falling edges would lose count. It also targets a zero offset, where the first pulse must start in the very first cycle, and trains that run past the frame end and must be cut off there. It changes parameters mid-frame to catch a design that copies them in immediately and tears the frame, sets counts and offsets that must produce no pulses, and toggles enable mid-frame to check that a new frame starts at position zero instead of resuming. A raster built from standard porch arithmetic confirms that DE lands on the intended active lines.

// File: rtl/stg_pkg.sv
package stg_pkg;
  parameter int unsigned STG_FW = 24;  // frame-position width
  parameter int unsigned STG_LW = 16;  // pulse width/count width
  parameter int unsigned STG_NT = 2;   // pulse trains: 0 = HS, 1 = DE

  typedef struct packed {
    logic [STG_FW-1:0] vs_dly;
    logic [STG_FW-1:0] vs_high;
    logic [STG_FW-1:0] vs_low;
    logic [STG_FW-1:0] h_off;
    logic [STG_LW-1:0] h_high;
    logic [STG_LW-1:0] h_low;
    logic [STG_LW-1:0] h_cnt;
    logic [STG_FW-1:0] d_off;
    logic [STG_LW-1:0] d_high;
    logic [STG_LW-1:0] d_low;
    logic [STG_LW-1:0] d_cnt;
  } stg_cfg_t;
endpackage

// File: rtl/stg_frame_timer.sv
module stg_frame_timer
  import stg_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  stg_cfg_t                       cfg_i,
  output logic                           on_o,
  output logic                           start_o,
  output logic                           first_o,
  output logic [STG_FW:0]                fc_nxt_o,
  output logic                           vs_o,
  output logic [STG_NT-1:0][STG_FW-1:0]  off_nxt_o,
  output logic [STG_NT-1:0][STG_LW-1:0]  cnt_nxt_o,
  output logic [STG_NT-1:0][STG_LW-1:0]  high_o,
  output logic [STG_NT-1:0][STG_LW-1:0]  low_o,
  output logic [STG_NT-1:0][STG_LW-1:0]  cnt_o
);
  localparam int unsigned PW = STG_FW + 1;

  stg_cfg_t          cfg_q;
  logic              on_q;
  logic [PW-1:0]     fc_q;
  logic [PW-1:0]     per;
  logic              wrap;

  assign per     = {1'b0, cfg_q.vs_high} + {1'b0, cfg_q.vs_low};
  assign wrap    = on_q && (({1'b0, fc_q} + 1'b1) >= {1'b0, per});
  assign start_o = en_i && (!on_q || wrap);
  assign fc_nxt_o = start_o ? '0 : fc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      fc_q  <= '0;
      cfg_q <= '0;
    end else if (!en_i) begin
      on_q <= 1'b0;
      fc_q <= '0;
    end else begin
      on_q <= 1'b1;
      fc_q <= fc_nxt_o;
      if (start_o) cfg_q <= cfg_i;
    end
  end

  assign on_o    = on_q;
  assign first_o = on_q && (fc_q == '0);
  assign vs_o    = on_q && ({1'b0, fc_q} >= {2'b0, cfg_q.vs_dly}) &&
                   ({1'b0, fc_q} < ({2'b0, cfg_q.vs_dly} + {2'b0, cfg_q.vs_high}));

  // next-cycle view: parameters being captured win over the shadow
  assign off_nxt_o[0] = start_o ? cfg_i.h_off : cfg_q.h_off;
  assign off_nxt_o[1] = start_o ? cfg_i.d_off : cfg_q.d_off;
  assign cnt_nxt_o[0] = start_o ? cfg_i.h_cnt : cfg_q.h_cnt;
  assign cnt_nxt_o[1] = start_o ? cfg_i.d_cnt : cfg_q.d_cnt;
  assign high_o[0] = cfg_q.h_high;
  assign high_o[1] = cfg_q.d_high;
  assign low_o[0]  = cfg_q.h_low;
  assign low_o[1]  = cfg_q.d_low;
  assign cnt_o[0]  = cfg_q.h_cnt;
  assign cnt_o[1]  = cfg_q.d_cnt;
endmodule

// File: rtl/stg_pulse_train.sv
module stg_pulse_train
  import stg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [STG_FW:0]   fc_nxt_i,
  input  logic [STG_FW-1:0] off_nxt_i,
  input  logic [STG_LW-1:0] cnt_nxt_i,
  input  logic [STG_LW-1:0] high_i,
  input  logic [STG_LW-1:0] low_i,
  input  logic [STG_LW-1:0] cnt_i,
  output logic              pulse_o,
  output logic [STG_LW-1:0] pos_o,
  output logic [STG_LW-1:0] idx_o
);
  localparam int unsigned PW = STG_LW + 1;

  logic              run_q;
  logic [PW-1:0]     pos_q;
  logic [PW-1:0]     per;
  logic [STG_LW-1:0] n_q;
  logic              hit;

  assign per = {1'b0, high_i} + {1'b0, low_i};
  assign hit = (fc_nxt_i == {1'b0, off_nxt_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pos_q <= '0;
      n_q   <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      pos_q <= '0;
      n_q   <= '0;
    end else if (hit) begin
      run_q <= (cnt_nxt_i != '0);
      pos_q <= '0;
      n_q   <= '0;
    end else if (start_i) begin
      run_q <= 1'b0;
      pos_q <= '0;
      n_q   <= '0;
    end else if (run_q) begin
      if (pos_q == per - 1'b1) begin
        pos_q <= '0;
        if (n_q == cnt_i - 1'b1) run_q <= 1'b0;
        else                     n_q   <= n_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pulse_o = run_q && (pos_q < {1'b0, high_i});
  assign pos_o   = pulse_o ? pos_q[STG_LW-1:0] : '0;
  assign idx_o   = n_q;
endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
  import stg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [STG_FW-1:0] vs_dly_i,
  input  logic [STG_FW-1:0] vs_high_i,
  input  logic [STG_FW-1:0] vs_low_i,
  input  logic [STG_FW-1:0] hs_off_i,
  input  logic [STG_LW-1:0] hs_high_i,
  input  logic [STG_LW-1:0] hs_low_i,
  input  logic [STG_LW-1:0] hs_cnt_i,
  input  logic [STG_FW-1:0] de_off_i,
  input  logic [STG_LW-1:0] de_high_i,
  input  logic [STG_LW-1:0] de_low_i,
  input  logic [STG_LW-1:0] de_cnt_i,
  output logic              vs_o,
  output logic              hs_o,
  output logic              de_o,
  output logic [STG_LW-1:0] pix_x_o,
  output logic [STG_LW-1:0] pix_y_o
);
  stg_cfg_t                        cfg;
  logic                            on;
  logic                            frame_start;
  logic                            frame_first;
  logic [STG_FW:0]                 fc_nxt;
  logic [STG_NT-1:0][STG_FW-1:0]   off_nxt;
  logic [STG_NT-1:0][STG_LW-1:0]   cnt_nxt;
  logic [STG_NT-1:0][STG_LW-1:0]   hi;
  logic [STG_NT-1:0][STG_LW-1:0]   lo;
  logic [STG_NT-1:0][STG_LW-1:0]   cnt;
  logic [STG_NT-1:0][STG_LW-1:0]   pos;
  logic [STG_NT-1:0][STG_LW-1:0]   idx;
  logic [STG_NT-1:0]               pls;

  assign cfg = '{vs_dly: vs_dly_i, vs_high: vs_high_i, vs_low: vs_low_i,
                 h_off: hs_off_i, h_high: hs_high_i, h_low: hs_low_i, h_cnt: hs_cnt_i,
                 d_off: de_off_i, d_high: de_high_i, d_low: de_low_i, d_cnt: de_cnt_i};

  stg_frame_timer u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .cfg_i     (cfg),
    .on_o      (on),
    .start_o   (frame_start),
    .first_o   (frame_first),
    .fc_nxt_o  (fc_nxt),
    .vs_o      (vs_o),
    .off_nxt_o (off_nxt),
    .cnt_nxt_o (cnt_nxt),
    .high_o    (hi),
    .low_o     (lo),
    .cnt_o     (cnt)
  );

  for (genvar g = 0; g < STG_NT; g++) begin : g_train
    stg_pulse_train u_train (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .start_i   (frame_start),
      .fc_nxt_i  (fc_nxt),
      .off_nxt_i (off_nxt[g]),
      .cnt_nxt_i (cnt_nxt[g]),
      .high_i    (hi[g]),
      .low_i     (lo[g]),
      .cnt_i     (cnt[g]),
      .pulse_o   (pls[g]),
      .pos_o     (pos[g]),
      .idx_o     (idx[g])
    );
  end

  assign hs_o    = on && pls[0];
  assign de_o    = on && pls[1];
  assign pix_x_o = on ? pos[1] : '0;
  assign pix_y_o = on ? idx[1] : '0;
endmodule

// File: rtl/sync_timing_gen_chk.sv
module sync_timing_gen_chk
  import stg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              frame_first_i,
  input logic              vs_o,
  input logic              hs_o,
  input logic              de_o,
  input logic [STG_LW-1:0] pix_x_o,
  input logic [STG_LW-1:0] pix_y_o,
  input logic [STG_LW-1:0] h_high_i,
  input logic [STG_LW-1:0] h_low_i,
  input logic [STG_LW-1:0] d_high_i,
  input logic [STG_LW-1:0] d_low_i,
  input logic [STG_LW-1:0] d_cnt_i
);
  logic        en_q, de_prev_q;
  logic [31:0] hs_len_q, de_len_q, de_rise_q;
  logic [31:0] hs_len, de_len, de_rise;

  assign hs_len  = hs_o ? (frame_first_i ? 32'd1 : hs_len_q + 32'd1) : 32'd0;
  assign de_len  = de_o ? (frame_first_i ? 32'd1 : de_len_q + 32'd1) : 32'd0;
  assign de_rise = (frame_first_i ? 32'd0 : de_rise_q) +
                   ((de_o && (!de_prev_q || frame_first_i)) ? 32'd1 : 32'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      de_prev_q <= 1'b0;
      hs_len_q  <= '0;
      de_len_q  <= '0;
      de_rise_q <= '0;
    end else begin
      en_q      <= en_i;
      de_prev_q <= de_o;
      hs_len_q  <= hs_len;
      de_len_q  <= de_len;
      de_rise_q <= de_rise;
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!vs_o && !hs_o && !de_o && pix_x_o == '0 && pix_y_o == '0));

  assert_hs_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_low_i != '0) |-> (hs_len <= {16'd0, h_high_i}));

  assert_de_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_low_i != '0) |-> (de_len <= {16'd0, d_high_i}));

  assert_de_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (de_rise <= {16'd0, d_cnt_i}));

  assert_pix_x_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (pix_x_o == '0));

  assert_pix_x_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (pix_x_o < d_high_i));
endmodule

bind sync_timing_gen sync_timing_gen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .frame_first_i (frame_first),
  .vs_o          (vs_o),
  .hs_o          (hs_o),
  .de_o          (de_o),
  .pix_x_o       (pix_x_o),
  .pix_y_o       (pix_y_o),
  .h_high_i      (hi[0]),
  .h_low_i       (lo[0]),
  .d_high_i      (hi[1]),
  .d_low_i       (lo[1]),
  .d_cnt_i       (cnt[1])
);

// File: tb/sim_sync_timing_gen.sv
`timescale 1ns/1ps
module sim_sync_timing_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [23:0] vs_dly = '0, vs_high = '0, vs_low = '0, hs_off = '0, de_off = '0;
  logic [15:0] hs_high = '0, hs_low = '0, hs_cnt = '0;
  logic [15:0] de_high = '0, de_low = '0, de_cnt = '0;
  logic        vs, hs, de;
  logic [15:0] px, py;

  int checks = 0;
  int errors = 0;

  // model state: position and shadow parameters
  bit     m_on = 0;
  longint m_k = 0;
  longint s_dly, s_vsh, s_vsl, s_hoff, s_hh, s_hl, s_hc, s_doff, s_dh, s_dl, s_dc;

  always #2 clk = ~clk;

  sync_timing_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .vs_dly_i(vs_dly), .vs_high_i(vs_high), .vs_low_i(vs_low),
    .hs_off_i(hs_off), .hs_high_i(hs_high), .hs_low_i(hs_low), .hs_cnt_i(hs_cnt),
    .de_off_i(de_off), .de_high_i(de_high), .de_low_i(de_low), .de_cnt_i(de_cnt),
    .vs_o(vs), .hs_o(hs), .de_o(de), .pix_x_o(px), .pix_y_o(py)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic train(input longint k, input longint off, input longint hi, input longint lo,
                       input longint cnt, output bit p, output longint pos, output longint idx);
    longint per, d;
    per = hi + lo; p = 0; pos = 0; idx = 0;
    if (cnt != 0 && k >= off) begin
      d = k - off;
      idx = d / per;
      if (idx > cnt - 1) idx = cnt - 1;
      if (d < cnt * per && (d % per) < hi) begin
        p = 1;
        pos = d % per;
      end
    end
  endtask

  task automatic model_step();
    if (!en) begin
      m_on = 0; m_k = 0;
    end else if (!m_on || m_k + 1 >= s_vsh + s_vsl) begin
      m_on = 1; m_k = 0;
      s_dly = vs_dly; s_vsh = vs_high; s_vsl = vs_low;
      s_hoff = hs_off; s_hh = hs_high; s_hl = hs_low; s_hc = hs_cnt;
      s_doff = de_off; s_dh = de_high; s_dl = de_low; s_dc = de_cnt;
    end else begin
      m_k++;
    end
  endtask

  // inputs are already applied; advance one edge and compare at the falling edge
  task automatic tick(input string tag);
    bit     e_vs, e_hs, e_de;
    longint hpos, hidx, dpos, didx;
    model_step();
    @(negedge clk);
    e_vs = 0; e_hs = 0; e_de = 0; dpos = 0; didx = 0;
    if (m_on) begin
      e_vs = (m_k >= s_dly) && (m_k < s_dly + s_vsh);
      train(m_k, s_hoff, s_hh, s_hl, s_hc, e_hs, hpos, hidx);
      train(m_k, s_doff, s_dh, s_dl, s_dc, e_de, dpos, didx);
    end
    if (!m_on) begin
      chk(vs == 0 && hs == 0 && de == 0, {tag, " R1 strobes"}, {vs, hs, de}, 0);
      chk(px == 0 && py == 0, {tag, " R1 indices"}, {px, py}, 0);
    end else begin
      chk(vs == e_vs, {tag, " R2 vs"}, vs, e_vs);
      chk(hs == e_hs, {tag, " R3 hs"}, hs, e_hs);
      chk(de == e_de, {tag, " R4 de"}, de, e_de);
      chk(px == dpos, {tag, " R5 pix_x"}, px, dpos);
      chk(py == didx, {tag, " R6 pix_y"}, py, didx);
    end
  endtask

  task automatic set_base();
    vs_dly = 1; vs_high = 6; vs_low = 20;
    hs_off = 2; hs_high = 3; hs_low = 2; hs_cnt = 4;
    de_off = 5; de_high = 4; de_low = 3; de_cnt = 3;
  endtask

  initial begin
    // R1: reset state and disabled state
    set_base();
    for (int i = 0; i < 4; i++) tick("R1 reset");
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) tick("R1 idle");

    // base timing, three frames
    en = 1'b1;
    for (int i = 0; i < 78; i++) tick("base");

    // standard raster arithmetic: 6 active px, porches 2/1/2; 3 lines, porches 1/1/2
    vs_dly = 0; vs_high = 1 * 11; vs_low = (3 + 1 + 2) * 11;
    hs_off = 0; hs_high = 1; hs_low = 10; hs_cnt = 7;
    de_off = 11 * (1 + 2) + (1 + 2); de_high = 6; de_low = 5; de_cnt = 3;
    for (int i = 0; i < 26 + 154; i++) tick("R4 raster");

    // R7: mid-frame change applies only from the next frame
    set_base();
    for (int i = 0; i < 40; i++) tick("R7 pre");
    hs_high = 1; hs_low = 1; hs_cnt = 6; de_off = 0; de_high = 2; de_low = 1; de_cnt = 5;
    vs_dly = 3; vs_high = 2; vs_low = 15;
    for (int i = 0; i < 60; i++) tick("R7 post");

    // R8: offset beyond the frame, zero count
    set_base();
    hs_off = 26; de_cnt = 0;
    for (int i = 0; i < 60; i++) tick("R8 silent");
    hs_off = 25; hs_cnt = 3; de_cnt = 2; de_off = 24;
    for (int i = 0; i < 60; i++) tick("R8 cutoff");

    // R9: enable drop mid-frame and restart
    set_base();
    for (int i = 0; i < 37; i++) tick("R9 run");
    en = 1'b0;
    for (int i = 0; i < 3; i++) tick("R9 off");
    en = 1'b1;
    for (int i = 0; i < 30; i++) tick("R9 restart");

    // sweep of the HS train shape (R3), including zero low width and zero offset
    set_base();
    for (int hh = 1; hh <= 3; hh++)
      for (int hl = 0; hl <= 2; hl++)
        for (int hc = 1; hc <= 3; hc++)
          for (int ho = 0; ho <= 3; ho++) begin
            hs_high = 16'(hh); hs_low = 16'(hl); hs_cnt = 16'(hc); hs_off = 24'(ho);
            for (int i = 0; i < 52; i++) tick("R3 sweep");
          end

    // sweep of the DE train shape (R4 R5 R6)
    for (int dh = 1; dh <= 4; dh++)
      for (int dl = 0; dl <= 2; dl++)
        for (int dc = 0; dc <= 4; dc++) begin
          de_high = 16'(dh); de_low = 16'(dl); de_cnt = 16'(dc); de_off = 24'(dc);
          for (int i = 0; i < 52; i++) tick("R6 sweep");
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule